// File: doc/BRIEF.md
# Two-Group Prioritised Interrupt Controller

This block collects interrupt requests for a processor and turns them into a single 4-bit interrupt level. There are fifteen request lines, numbered 1 to 15, and line 0 does not exist. A rising edge on a line either records the interrupt in a shared pending register or, for lines marked for broadcast, sets that bit in the force register of every processor. For processor 0, the active set is the pending and force bits combined and then filtered through that processor's mask. A priority register splits the active set into a high and a low group. The output is the highest active number in the high group, or in the low group when the high group is empty.

Software reaches all state through a small 32-bit register port with an 8-bit byte address. The port writes in one cycle and has a combinational read. Mask, force and a 4-bit auxiliary register are kept for up to sixteen processors, but only processor 0 drives the output. The processor acknowledges an interrupt by giving its number on a strobe. This clears that bit in the pending register and in processor 0's force register.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq_level` is 0.
- R2: Bit 0 of the priority, pending, force, mask and broadcast registers is always 0. Written data bit 0 is dropped, and request line 0 has no effect.
- R3: Writes to the pending register (byte offset 0x04) and to the status word (0x10) are ignored. The clear word (0x0C) and the status word always read 0.
- R4: A request line going from 0 to 1 between two rising clock edges sets its pending bit, unless its broadcast bit is set. A line held at 1 does not set the bit again.
- R5: A rising request on a line whose bit is set in the broadcast register (0x14) sets that bit in the force register of every processor and leaves the pending bit unchanged.
- R6: The active set is (pending OR force of processor 0) AND mask of processor 0 (0x40). Active bits whose bit is 1 in the priority register (0x00) form the high group. `irq_level` is the highest number in the high group if that group is non-empty, otherwise the highest number in the active set, and 0 when nothing is active.
- R7: Pulsing `ack_en` with `ack_num` = k clears bit k of the pending register and of processor 0's force register. If a rising request on line k arrives in the same cycle, the bit stays set.
- R8: Writing the clear word (0x0C) clears every pending bit that is 1 in written bits 15:1.
- R9: A write at 0x80 + 4·n sets force bits from data bits 15:1 and clears force bits given by data bits 31:17, and clearing wins over setting. A write at 0x08 replaces processor 0's force register with data bits 15:1.
- R10: The auxiliary register at 0xC0 + 4·n keeps only bits 3:0 of a write.
- R11: The mask and force registers of processors other than 0 have no effect on `irq_level`.
- R12: Byte offsets 0x18 to 0x3F, and any address with bits 1:0 not equal to 00, read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 16 | Request lines; bit i is line i |
| ack_en | input | 1 | Acknowledge strobe |
| ack_num | input | 4 | Interrupt number being acknowledged |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_level | output | 4 | Interrupt level presented to processor 0 |

## Verification
The bench raises a request and acknowledges the same number in the same cycle. A design that gives the acknowledge the last word would silently drop an interrupt. It holds a request line high through a clear. A level-sensitive design would set the pending bit again, while the edge rule leaves it cleared. It makes a low-numbered high-group interrupt compete with a higher-numbered low-group one, which shows whether the group split is applied before the numeric priority. It also issues a force write that both sets and clears the same bit, and it sends broadcast lines and writes to unaligned and unmapped addresses. A wrong bit precedence, a broadcast that lands in pending, or a loose decoder would each show up as a register read-back that differs.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   // Byte-address map; the word index (address bits 7:2) selects a register.
   localparam int MAP_AW        = 8;
   localparam int CPU_FIELD_W   = 4;
   localparam int WORD_PRIO     = 0;
   localparam int WORD_PEND     = 1;
   localparam int WORD_ALIAS    = 2;
   localparam int WORD_CLEAR    = 3;
   localparam int WORD_STATUS   = 4;
   localparam int WORD_BCAST    = 5;
   localparam logic [1:0] BANK_MASK  = 2'b01;
   localparam logic [1:0] BANK_FORCE = 2'b10;
   localparam logic [1:0] BANK_AUX   = 2'b11;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_PRIO,
      SEL_PEND,
      SEL_ALIAS,
      SEL_CLEAR,
      SEL_STATUS,
      SEL_BCAST,
      SEL_MASK,
      SEL_FORCE,
      SEL_AUX
   } reg_sel_e;

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
   import prio_irq_pkg::*;
#(
   parameter int NUM_CPU = 16,
   parameter int ADDR_W  = 8
) (
   input  logic [ADDR_W-1:0]      addr,
   output reg_sel_e               sel,
   output logic [CPU_FIELD_W-1:0] cpu_idx
);

   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic [1:0]        bank;

   assign word    = addr[ADDR_W-1:2];
   assign bank    = word[WORD_W-1 -: 2];
   assign cpu_idx = word[CPU_FIELD_W-1:0];

   always_comb begin
      sel = SEL_NONE;
      if (addr[1:0] == 2'b00) begin
         if (bank == 2'b00) begin
            case (int'(word))
               WORD_PRIO:   sel = SEL_PRIO;
               WORD_PEND:   sel = SEL_PEND;
               WORD_ALIAS:  sel = SEL_ALIAS;
               WORD_CLEAR:  sel = SEL_CLEAR;
               WORD_STATUS: sel = SEL_STATUS;
               WORD_BCAST:  sel = SEL_BCAST;
               default:     sel = SEL_NONE;
            endcase
         end else if (int'(cpu_idx) < NUM_CPU) begin
            case (bank)
               BANK_MASK:  sel = SEL_MASK;
               BANK_FORCE: sel = SEL_FORCE;
               default:    sel = SEL_AUX;
            endcase
         end
      end
   end

endmodule

// File: rtl/irq_cpu_bank.sv
module irq_cpu_bank #(
   parameter int NUM_LINES = 16,
   parameter int DATA_W    = 32,
   parameter int EXT_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mask_we,
   input  logic                 force_we,
   input  logic                 alias_we,
   input  logic                 aux_we,
   input  logic [NUM_LINES-1:0] ack_clr,
   input  logic [NUM_LINES-1:0] bcast_set,
   input  logic [DATA_W-1:0]    wdata,
   output logic [NUM_LINES-1:0] mask_q,
   output logic [NUM_LINES-1:0] force_q,
   output logic [EXT_W-1:0]     aux_q
);

   localparam int CLR_LSB = DATA_W / 2;
   localparam logic [NUM_LINES-1:0] LINE_MASK = {{(NUM_LINES-1){1'b1}}, 1'b0};

   logic [NUM_LINES-1:0] set_bits;
   logic [NUM_LINES-1:0] clr_bits;
   logic [NUM_LINES-1:0] force_d;
   logic [DATA_W-CLR_LSB-NUM_LINES-1:0] spare_hi;
   logic [CLR_LSB-NUM_LINES-1:0]        spare_lo;

   assign set_bits = wdata[NUM_LINES-1:0] & LINE_MASK;
   assign clr_bits = wdata[CLR_LSB +: NUM_LINES] & LINE_MASK;
   assign spare_hi = '0;
   assign spare_lo = '0;

   // Order inside one cycle: acknowledge, then software, then new requests.
   always_comb begin
      force_d = force_q & ~ack_clr;
      if (force_we) force_d = (force_d | set_bits) & ~clr_bits;
      if (alias_we) force_d = set_bits;
      force_d = force_d | (bcast_set & LINE_MASK);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '0;
         force_q <= '0;
         aux_q   <= '0;
      end else begin
         force_q <= force_d;
         if (mask_we) mask_q <= wdata[NUM_LINES-1:0] & LINE_MASK;
         if (aux_we)  aux_q  <= wdata[EXT_W-1:0];
      end
   end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
   parameter int NUM_LINES = 16,
   parameter int LVL_W     = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] pend,
   input  logic [NUM_LINES-1:0] force0,
   input  logic [NUM_LINES-1:0] mask0,
   input  logic [NUM_LINES-1:0] grp_hi,
   output logic [LVL_W-1:0]     level
);

   logic [NUM_LINES-1:0] active;
   logic [NUM_LINES-1:0] hi_set;
   logic [NUM_LINES-1:0] pick;

   assign active = (pend | force0) & mask0;
   assign hi_set = active & grp_hi;
   assign pick   = (hi_set != '0) ? hi_set : active;

   always_comb begin
      level = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (pick[i]) level = LVL_W'(i);
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int NUM_CPU   = 16,
   parameter int NUM_LINES = 16,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int EXT_W     = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_LINES-1:0]         irq_req,
   input  logic                         ack_en,
   input  logic [$clog2(NUM_LINES)-1:0] ack_num,
   input  logic                         reg_we,
   input  logic [ADDR_W-1:0]            reg_addr,
   input  logic [DATA_W-1:0]            reg_wdata,
   output logic [DATA_W-1:0]            reg_rdata,
   output logic [$clog2(NUM_LINES)-1:0] irq_level
);

   localparam int LVL_W = $clog2(NUM_LINES);
   localparam logic [NUM_LINES-1:0] LINE_MASK = {{(NUM_LINES-1){1'b1}}, 1'b0};

   // Elaboration-time parameter checks
   if (NUM_CPU < 1 || NUM_CPU > (1 << CPU_FIELD_W)) begin : g_bad_cpu
      $error("NUM_CPU must lie in 1..16");
   end
   if (NUM_LINES != (1 << LVL_W) || NUM_LINES < 2) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (2 * NUM_LINES > DATA_W) begin : g_bad_data
      $error("DATA_W must hold separate set and clear halves");
   end
   if (ADDR_W != MAP_AW) begin : g_bad_addr
      $error("ADDR_W must match the 8-bit register map");
   end
   if (EXT_W > DATA_W) begin : g_bad_ext
      $error("EXT_W must fit in DATA_W");
   end

   reg_sel_e               sel;
   logic [CPU_FIELD_W-1:0] cpu_sel;
   logic                   wr_ok;

   logic [NUM_LINES-1:0] req_q;
   logic [NUM_LINES-1:0] pend_q;
   logic [NUM_LINES-1:0] lvl_q;
   logic [NUM_LINES-1:0] bcast_q;
   logic [NUM_LINES-1:0] rise;
   logic [NUM_LINES-1:0] rise_pend;
   logic [NUM_LINES-1:0] rise_bcast;
   logic [NUM_LINES-1:0] ack_vec;
   logic [NUM_LINES-1:0] pend_d;

   logic [NUM_LINES-1:0] mask_arr  [NUM_CPU];
   logic [NUM_LINES-1:0] force_arr [NUM_CPU];
   logic [EXT_W-1:0]     aux_arr   [NUM_CPU];

   irq_addr_dec #(
      .NUM_CPU (NUM_CPU),
      .ADDR_W  (ADDR_W)
   ) u_dec (
      .addr    (reg_addr),
      .sel     (sel),
      .cpu_idx (cpu_sel)
   );

   assign wr_ok      = reg_we;
   assign rise       = irq_req & ~req_q & LINE_MASK;
   assign rise_pend  = rise & ~bcast_q;
   assign rise_bcast = rise & bcast_q;
   assign ack_vec    = ack_en ? ((NUM_LINES'(1) << ack_num) & LINE_MASK) : '0;

   always_comb begin
      pend_d = pend_q & ~ack_vec;
      if (wr_ok && sel == SEL_CLEAR) pend_d = pend_d & ~(reg_wdata[NUM_LINES-1:0] & LINE_MASK);
      pend_d = pend_d | rise_pend;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q   <= '0;
         pend_q  <= '0;
         lvl_q   <= '0;
         bcast_q <= '0;
      end else begin
         req_q  <= irq_req;
         pend_q <= pend_d;
         if (wr_ok && sel == SEL_PRIO)  lvl_q   <= reg_wdata[NUM_LINES-1:0] & LINE_MASK;
         if (wr_ok && sel == SEL_BCAST) bcast_q <= reg_wdata[NUM_LINES-1:0] & LINE_MASK;
      end
   end

   // Per-processor state; processor 0 alone sees the alias and the acknowledge.
   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic                 alias_we_c;
      logic [NUM_LINES-1:0] ack_clr_c;
      logic                 sel_me;

      assign sel_me = (cpu_sel == CPU_FIELD_W'(c));

      if (c == 0) begin : g_primary
         assign alias_we_c = wr_ok && (sel == SEL_ALIAS);
         assign ack_clr_c  = ack_vec;
      end else begin : g_secondary
         assign alias_we_c = 1'b0;
         assign ack_clr_c  = '0;
      end

      irq_cpu_bank #(
         .NUM_LINES (NUM_LINES),
         .DATA_W    (DATA_W),
         .EXT_W     (EXT_W)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .mask_we   (wr_ok && sel == SEL_MASK  && sel_me),
         .force_we  (wr_ok && sel == SEL_FORCE && sel_me),
         .alias_we  (alias_we_c),
         .aux_we    (wr_ok && sel == SEL_AUX   && sel_me),
         .ack_clr   (ack_clr_c),
         .bcast_set (rise_bcast),
         .wdata     (reg_wdata),
         .mask_q    (mask_arr[c]),
         .force_q   (force_arr[c]),
         .aux_q     (aux_arr[c])
      );
   end

   irq_prio_sel #(
      .NUM_LINES (NUM_LINES),
      .LVL_W     (LVL_W)
   ) u_sel (
      .pend   (pend_q),
      .force0 (force_arr[0]),
      .mask0  (mask_arr[0]),
      .grp_hi (lvl_q),
      .level  (irq_level)
   );

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_PRIO:  reg_rdata = DATA_W'(lvl_q);
         SEL_PEND:  reg_rdata = DATA_W'(pend_q);
         SEL_ALIAS: reg_rdata = DATA_W'(force_arr[0]);
         SEL_BCAST: reg_rdata = DATA_W'(bcast_q);
         SEL_MASK:  reg_rdata = DATA_W'(mask_arr[cpu_sel]);
         SEL_FORCE: reg_rdata = DATA_W'(force_arr[cpu_sel]);
         SEL_AUX:   reg_rdata = DATA_W'(aux_arr[cpu_sel]);
         default:   reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int NUM_LINES = 16,
   parameter int LVL_W     = $clog2(NUM_LINES)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_req,
   input logic [NUM_LINES-1:0] req_q,
   input logic [NUM_LINES-1:0] pend_q,
   input logic [NUM_LINES-1:0] bcast_q,
   input logic [NUM_LINES-1:0] lvl_q,
   input logic [NUM_LINES-1:0] force0,
   input logic [NUM_LINES-1:0] mask0,
   input logic                 ack_en,
   input logic [LVL_W-1:0]     ack_num,
   input logic                 reg_we,
   input logic [LVL_W-1:0]     irq_level
);

   localparam logic [NUM_LINES-1:0] LINE_MASK = {{(NUM_LINES-1){1'b1}}, 1'b0};

   logic [NUM_LINES-1:0] edge_nb;
   logic [NUM_LINES-1:0] edge_b;
   logic [NUM_LINES-1:0] act;
   logic [NUM_LINES-1:0] act_hi;

   assign edge_nb = irq_req & ~req_q & ~bcast_q & LINE_MASK;
   assign edge_b  = irq_req & ~req_q & bcast_q & LINE_MASK;
   assign act     = (pend_q | force0) & mask0;
   assign act_hi  = act & lvl_q;

   // R2
   bit0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q[0] && !force0[0] && !mask0[0] && !lvl_q[0] && !bcast_q[0]);

   // R3
   pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((pend_q & ~$past(pend_q) & ~$past(edge_nb)) == '0));

   // R4
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_nb != '0) |=> ((pend_q & $past(edge_nb)) == $past(edge_nb)));

   // R5
   bcast_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_b != '0) |=> ((force0 & $past(edge_b)) == $past(edge_b)));

   // R6
   level_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level != '0) |-> act[irq_level]);

   // R6
   level_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act != '0) |-> (irq_level != '0));

   // R6
   level_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_hi != '0) |-> lvl_q[irq_level]);

   // R7
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_en && ack_num != '0 && !reg_we && !(irq_req[ack_num] && !req_q[ack_num]))
      |=> (!pend_q[$past(ack_num)] && !force0[$past(ack_num)]));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_req   (irq_req),
   .req_q     (req_q),
   .pend_q    (pend_q),
   .bcast_q   (bcast_q),
   .lvl_q     (lvl_q),
   .force0    (force_arr[0]),
   .mask0     (mask_arr[0]),
   .ack_en    (ack_en),
   .ack_num   (ack_num),
   .reg_we    (reg_we),
   .irq_level (irq_level)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] req = '0;
   logic        ack_en = 1'b0;
   logic [3:0]  ack_num = '0;
   logic        we = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  level;

   int checks = 0;
   int errors = 0;
   bit run_cmp = 0;

   always #10 clk = ~clk;   // 50 MHz

   prio_irq_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_req   (req),
      .ack_en    (ack_en),
      .ack_num   (ack_num),
      .reg_we    (we),
      .reg_addr  (addr),
      .reg_wdata (wdata),
      .reg_rdata (rdata),
      .irq_level (level)
   );

   // Behavioural reference model
   bit [15:0] m_pend, m_lvl, m_bc, m_prev, m_bc_old;
   bit [15:0] m_mask [16];
   bit [15:0] m_force [16];
   bit [3:0]  m_aux [16];
   int        m_word;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = 0; m_lvl = 0; m_bc = 0; m_prev = 0;
         for (int i = 0; i < 16; i++) begin m_mask[i] = 0; m_force[i] = 0; m_aux[i] = 0; end
      end else begin
         m_bc_old = m_bc;
         if (ack_en) begin m_pend[ack_num] = 0; m_force[0][ack_num] = 0; end
         if (we && addr[1:0] == 2'b00) begin
            m_word = int'(addr[7:2]);
            if (m_word == 0) m_lvl = wdata[15:0] & 16'hFFFE;
            else if (m_word == 2) m_force[0] = wdata[15:0] & 16'hFFFE;
            else if (m_word == 3) m_pend = m_pend & ~(wdata[15:0] & 16'hFFFE);
            else if (m_word == 5) m_bc = wdata[15:0] & 16'hFFFE;
            else if (m_word >= 16 && m_word < 32) m_mask[m_word-16] = wdata[15:0] & 16'hFFFE;
            else if (m_word >= 32 && m_word < 48)
               m_force[m_word-32] = (m_force[m_word-32] | (wdata[15:0] & 16'hFFFE)) & ~(wdata[31:16] & 16'hFFFE);
            else if (m_word >= 48) m_aux[m_word-48] = wdata[3:0];
         end
         for (int i = 1; i < 16; i++) begin
            if (req[i] && !m_prev[i]) begin
               if (m_bc_old[i]) begin
                  for (int c = 0; c < 16; c++) m_force[c][i] = 1;
               end else m_pend[i] = 1;
            end
         end
         m_prev = req;
      end
   end

   function automatic logic [3:0] m_level();
      bit [15:0] a, g;
      logic [3:0] r;
      a = (m_pend | m_force[0]) & m_mask[0];
      g = ((a & m_lvl) != 0) ? (a & m_lvl) : a;
      r = 0;
      for (int i = 15; i >= 1; i--) if (g[i] && r == 0) r = 4'(i);
      return r;
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      int w;
      w = int'(a[7:2]);
      if (a[1:0] != 0) return 0;
      if (w == 0) return {16'h0, m_lvl};
      if (w == 1) return {16'h0, m_pend};
      if (w == 2) return {16'h0, m_force[0]};
      if (w == 5) return {16'h0, m_bc};
      if (w >= 16 && w < 32) return {16'h0, m_mask[w-16]};
      if (w >= 32 && w < 48) return {16'h0, m_force[w-32]};
      if (w >= 48) return {28'h0, m_aux[w-48]};
      return 0;
   endfunction

   // R6 and R11: output level compared with the model on every clock
   always @(negedge clk) begin
      if (run_cmp && rst_n) begin
         checks++;
         if (level !== m_level()) begin
            errors++;
            $display("FAIL R6 level at %0t: got %0d expected %0d", $time, level, m_level());
         end
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); #1; we = 1; addr = a; wdata = d;
      @(negedge clk); #1; we = 0; wdata = 0;
   endtask

   task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); #1; addr = a; #5;
      checks++;
      if (rdata !== exp) begin
         errors++;
         $display("FAIL %s read 0x%02h: got 0x%08h expected 0x%08h", tag, a, rdata, exp);
      end
   endtask

   task automatic rd_chk(input logic [7:0] a, input string tag);
      rd_exp(a, m_read(a), tag);
   endtask

   task automatic lvl_exp(input logic [3:0] exp, input string tag);
      @(negedge clk); #1;
      checks++;
      if (level !== exp) begin
         errors++;
         $display("FAIL %s level: got %0d expected %0d", tag, level, exp);
      end
   endtask

   task automatic pulse(input int n);
      @(negedge clk); #1; req[n] = 1;
      @(negedge clk); #1; req[n] = 0;
   endtask

   task automatic ack(input logic [3:0] k);
      @(negedge clk); #1; ack_en = 1; ack_num = k;
      @(negedge clk); #1; ack_en = 0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      cyc(3);
      rst_n = 1;
      run_cmp = 1;
      // R1 reset state
      lvl_exp(0, "R1");
      for (int a = 0; a < 256; a += 4) rd_exp(8'(a), 0, "R1");

      // R2 bit 0 dropped on writes
      wr(8'h00, 32'hFFFF_FFFF); rd_exp(8'h00, 32'h0000_FFFE, "R2");
      wr(8'h00, 0);
      wr(8'h14, 32'hFFFF_FFFF); rd_exp(8'h14, 32'h0000_FFFE, "R2");
      wr(8'h14, 0);
      wr(8'h40, 32'hFFFF_FFFF); rd_exp(8'h40, 32'h0000_FFFE, "R2");

      // R3 read-only and zero words
      wr(8'h04, 32'h0000_FFFF); rd_exp(8'h04, 0, "R3");
      wr(8'h10, 32'hFFFF_FFFF); rd_exp(8'h10, 0, "R3");
      rd_exp(8'h0C, 0, "R3");

      // R4 rising requests
      pulse(3); rd_exp(8'h04, 32'h8, "R4"); lvl_exp(3, "R4");
      pulse(5); rd_exp(8'h04, 32'h28, "R4"); lvl_exp(5, "R6");
      pulse(0); rd_exp(8'h04, 32'h28, "R2");

      // R8 clear while line held high: no re-set (R4)
      @(negedge clk); #1; req[5] = 1;
      cyc(1);
      wr(8'h0C, 32'h0000_0021);
      cyc(2);
      rd_exp(8'h04, 32'h8, "R8");
      lvl_exp(3, "R4");
      @(negedge clk); #1; req[5] = 0;

      // R6 high group beats a higher low-group number
      pulse(5); lvl_exp(5, "R6");
      wr(8'h00, 32'h0000_0008); lvl_exp(3, "R6");
      wr(8'h00, 0); lvl_exp(5, "R6");

      // R7 acknowledge, and coincidence with a new request
      ack(5); rd_exp(8'h04, 32'h8, "R7"); lvl_exp(3, "R7");
      @(negedge clk); #1; req[7] = 1; ack_en = 1; ack_num = 7;
      @(negedge clk); #1; req[7] = 0; ack_en = 0;
      rd_exp(8'h04, 32'h88, "R7");
      ack(7); ack(3); rd_exp(8'h04, 0, "R7"); lvl_exp(0, "R7");

      // R5 broadcast line goes to every force register
      wr(8'h14, 32'h0000_0200);
      pulse(9);
      rd_exp(8'h04, 0, "R5");
      rd_exp(8'h80, 32'h200, "R5");
      rd_exp(8'h08, 32'h200, "R5");
      rd_exp(8'hBC, 32'h200, "R5");
      lvl_exp(9, "R5");

      // R9 set/clear halves and alias replace
      wr(8'h88, 32'h0004_0006); rd_exp(8'h88, 32'h202, "R9");
      wr(8'h08, 32'h0000_0011); rd_exp(8'h80, 32'h10, "R9"); lvl_exp(4, "R9");

      // R10 auxiliary keeps four bits
      wr(8'hC4, 32'hFFFF_FFFF); rd_exp(8'hC4, 32'hF, "R10");

      // R12 unaligned and unmapped addresses
      wr(8'h45, 32'hFFFF_FFFF); rd_exp(8'h44, 0, "R12"); rd_exp(8'h45, 0, "R12");
      wr(8'h20, 32'hFFFF_FFFF); wr(8'h3C, 32'hFFFF_FFFF);
      rd_exp(8'h20, 0, "R12"); rd_exp(8'h18, 0, "R12");

      // R11 other processors do not drive the output
      wr(8'h40, 0);
      wr(8'h44, 32'h0000_FFFE);
      wr(8'h84, 32'h0000_00F0);
      lvl_exp(0, "R11");
      rd_exp(8'h84, 32'h2F0, "R11");

      // Full map sweep against the model
      for (int a = 0; a < 256; a += 4) rd_chk(8'(a), "R12");
      cyc(2);
      finish_run();
   end

endmodule